// File: doc/BRIEF.md
# Register-Amount Barrel Shifter with Carry-Out

This block shifts or rotates a 32-bit operand by an amount taken from a general register. It supports four operations: logical left, logical right, arithmetic right and rotate right. Each result comes with a carry-out bit and a carry-update flag. The consumer writes the carry-out into its carry flag only when the update flag is high. When the flag is low, the consumer keeps its previous carry.

Only the low 8 bits of the amount input take part. This means amounts of 32 and above are legal and have exact, defined results. A zero amount is transparent. A rotate whose amount is a nonzero multiple of 32 leaves the data unchanged but still produces a carry. The shifter itself is combinational. A parameter adds one output register stage; by default the register is present, so results appear one clock after the inputs.

Top module: `regshift_unit`

## Requirements
- R1: Only bits [7:0] of `amtIn` form the shift amount. Bits [31:8] have no effect on any output.
- R2: With an amount of zero, `dataOut` equals `dataIn` for every opcode and `carryUpd` is 0.
- R3: Opcode 2'b00 is logical left. For amounts 1..31 the result is `dataIn << n` with carry `dataIn[32-n]`. An amount of 32 gives 0 with carry `dataIn[0]`. Amounts above 32 give 0 with carry 0.
- R4: Opcode 2'b01 is logical right. For amounts 1..31 the result is `dataIn >> n` with carry `dataIn[n-1]`. An amount of 32 gives 0 with carry `dataIn[31]`. Amounts above 32 give 0 with carry 0.
- R5: Opcode 2'b10 is arithmetic right. For amounts 1..31 the result is the sign-filling shift with carry `dataIn[n-1]`. For amounts of 32 and above, every result bit equals `dataIn[31]` and the carry is `dataIn[31]`.
- R6: Opcode 2'b11 is rotate right by r = amount[4:0]. For r nonzero the result is the rotation and the carry is `dataIn[r-1]`.
- R7: For a rotate whose amount[4:0] is zero but whose 8-bit amount is nonzero, `dataOut` equals `dataIn` and the carry is `dataIn[31]`.
- R8: `carryUpd` is 1 for every nonzero 8-bit amount. Whenever `carryUpd` is 0, `carryOut` is 0.
- R9: With REG_OUT=1, outputs follow their inputs after exactly one rising clock edge. An active-low reset clears `dataOut`, `carryOut` and `carryUpd` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rstN | input | 1 | Asynchronous active-low reset |
| opSel | input | 2 | Operation: 00 logical left, 01 logical right, 10 arithmetic right, 11 rotate right |
| dataIn | input | 32 | Operand to shift |
| amtIn | input | 32 | Shift amount register; only bits [7:0] are used |
| dataOut | output | 32 | Shifted or rotated result |
| carryOut | output | 1 | Carry-out bit of the operation |
| carryUpd | output | 1 | High when the consumer should load `carryOut` into its carry flag |

## Verification
A wrong decode of the amount class shows up on the very next registered output. For example, a 32 treated as "above 32" or a rotate wrap treated as a zero amount each give a zero word where data was expected, a carry taken from the wrong end, or a dropped `carryUpd`, all within one clock. A fault in one barrel stage corrupts only the amounts with that stage's bit set. For this reason, random amounts spread over all 8 bits are mixed with directed values at 0, 1, 31, 32, 33, 64 and 255. The carry index logic fails mostly at the boundaries n=1 and n=31, so those are exercised directly for every opcode.

// File: rtl/regshift_pkg.sv
package regshift_pkg;

  typedef enum logic [1:0] {
    OP_LSL = 2'b00,
    OP_LSR = 2'b01,
    OP_ASR = 2'b10,
    OP_ROR = 2'b11
  } shiftOp_e;

  typedef enum logic [2:0] {
    CY_NONE  = 3'd0,
    CY_ZERO  = 3'd1,
    CY_LSB   = 3'd2,
    CY_MSB   = 3'd3,
    CY_SHIFT = 3'd4
  } carrySrc_e;

  // strobes from control to datapath
  typedef struct packed {
    logic      dirLeft;
    logic      fillSign;
    logic      fillWrap;
    logic      passThru;
    logic      forceZero;
    logic      forceSign;
    carrySrc_e carrySrc;
  } shiftCtrl_t;

endpackage

// File: rtl/regshift_ctrl.sv
module regshift_ctrl
  import regshift_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int AMT_USE_W = 8,
  localparam int LOG_W    = $clog2(DATA_W)
) (
  input  logic [1:0]           opSel,
  input  logic [AMT_USE_W-1:0] amtUse,
  output shiftCtrl_t           ctrl,
  output logic [LOG_W-1:0]     shamt
);

  logic amtZero;
  logic amtEqW;
  logic amtGtW;
  logic rotWrap;

  always_comb begin
    amtZero = (amtUse == '0);
    amtEqW  = (int'(amtUse) == DATA_W);
    amtGtW  = (int'(amtUse) > DATA_W);
    rotWrap = (amtUse[LOG_W-1:0] == '0);
    shamt   = amtUse[LOG_W-1:0];
  end

  always_comb begin
    ctrl = '{dirLeft: 1'b0, fillSign: 1'b0, fillWrap: 1'b0, passThru: 1'b0,
             forceZero: 1'b0, forceSign: 1'b0, carrySrc: CY_SHIFT};
    if (amtZero) begin
      ctrl.passThru = 1'b1;
      ctrl.carrySrc = CY_NONE;
    end else begin
      unique case (shiftOp_e'(opSel))
        OP_LSL: begin
          ctrl.dirLeft = 1'b1;
          if (amtGtW) begin
            ctrl.forceZero = 1'b1;
            ctrl.carrySrc  = CY_ZERO;
          end else if (amtEqW) begin
            ctrl.forceZero = 1'b1;
            ctrl.carrySrc  = CY_LSB;
          end
        end
        OP_LSR: begin
          if (amtGtW) begin
            ctrl.forceZero = 1'b1;
            ctrl.carrySrc  = CY_ZERO;
          end else if (amtEqW) begin
            ctrl.forceZero = 1'b1;
            ctrl.carrySrc  = CY_MSB;
          end
        end
        OP_ASR: begin
          ctrl.fillSign = 1'b1;
          if (amtGtW || amtEqW) begin
            ctrl.forceSign = 1'b1;
            ctrl.carrySrc  = CY_MSB;
          end
        end
        OP_ROR: begin
          ctrl.fillWrap = 1'b1;
          if (rotWrap) begin
            ctrl.passThru = 1'b1;
            ctrl.carrySrc = CY_MSB;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/regshift_datapath.sv
module regshift_datapath
  import regshift_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int LOG_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] dataIn,
  input  shiftCtrl_t        ctrl,
  input  logic [LOG_W-1:0]  shamt,
  output logic [DATA_W-1:0] resData,
  output logic              resCarry,
  output logic              resUpd
);

  logic [DATA_W-1:0]          srcWord;
  logic [DATA_W-1:0]          shiftedWord;
  logic [LOG_W:0][DATA_W-1:0] stg;
  logic                       fillBit;
  logic [LOG_W-1:0]           carryIdx;

  // left shifts run through the right shifter on a mirrored word
  always_comb begin
    for (int i = 0; i < DATA_W; i++) begin
      srcWord[i] = ctrl.dirLeft ? dataIn[DATA_W-1-i] : dataIn[i];
    end
  end

  assign fillBit = ctrl.fillSign & dataIn[DATA_W-1];
  assign stg[0]  = srcWord;

  for (genvar k = 0; k < LOG_W; k++) begin : g_stage
    localparam int SH = 1 << k;
    logic [DATA_W-1:0] moved;
    assign moved = ctrl.fillWrap ? {stg[k][SH-1:0], stg[k][DATA_W-1:SH]}
                                 : {{SH{fillBit}}, stg[k][DATA_W-1:SH]};
    assign stg[k+1] = shamt[k] ? moved : stg[k];
  end

  always_comb begin
    for (int i = 0; i < DATA_W; i++) begin
      shiftedWord[i] = ctrl.dirLeft ? stg[LOG_W][DATA_W-1-i] : stg[LOG_W][i];
    end
  end

  always_comb begin
    if (ctrl.passThru)       resData = dataIn;
    else if (ctrl.forceZero) resData = '0;
    else if (ctrl.forceSign) resData = {DATA_W{dataIn[DATA_W-1]}};
    else                     resData = shiftedWord;
  end

  // carry index: DATA_W-n for left (mod width), n-1 for right
  assign carryIdx = ctrl.dirLeft ? LOG_W'(~shamt + 1'b1) : LOG_W'(shamt - 1'b1);

  always_comb begin
    unique case (ctrl.carrySrc)
      CY_LSB:   resCarry = dataIn[0];
      CY_MSB:   resCarry = dataIn[DATA_W-1];
      CY_SHIFT: resCarry = dataIn[carryIdx];
      default:  resCarry = 1'b0;
    endcase
    resUpd = (ctrl.carrySrc != CY_NONE);
  end

endmodule

// File: rtl/regshift_unit.sv
module regshift_unit
  import regshift_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int AMT_IN_W  = 32,
  parameter int AMT_USE_W = 8,
  parameter bit REG_OUT   = 1'b1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [1:0]          opSel,
  input  logic [DATA_W-1:0]   dataIn,
  input  logic [AMT_IN_W-1:0] amtIn,
  output logic [DATA_W-1:0]   dataOut,
  output logic                carryOut,
  output logic                carryUpd
);

  localparam int LOG_W = $clog2(DATA_W);

  shiftCtrl_t        ctrl;
  logic [LOG_W-1:0]  shamt;
  logic [DATA_W-1:0] resData;
  logic              resCarry;
  logic              resUpd;

  regshift_ctrl #(.DATA_W(DATA_W), .AMT_USE_W(AMT_USE_W)) u_ctrl (
    .opSel (opSel),
    .amtUse(amtIn[AMT_USE_W-1:0]),
    .ctrl  (ctrl),
    .shamt (shamt)
  );

  regshift_datapath #(.DATA_W(DATA_W)) u_dp (
    .dataIn  (dataIn),
    .ctrl    (ctrl),
    .shamt   (shamt),
    .resData (resData),
    .resCarry(resCarry),
    .resUpd  (resUpd)
  );

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        dataOut  <= '0;
        carryOut <= 1'b0;
        carryUpd <= 1'b0;
      end else begin
        dataOut  <= resData;
        carryOut <= resCarry;
        carryUpd <= resUpd;
      end
    end
  end else begin : g_comb
    assign dataOut  = resData;
    assign carryOut = resCarry;
    assign carryUpd = resUpd;
  end

endmodule

// File: rtl/regshift_checker.sv
module regshift_checker #(
  parameter int DATA_W    = 32,
  parameter int AMT_IN_W  = 32,
  parameter int AMT_USE_W = 8,
  parameter bit REG_OUT   = 1'b1
) (
  input logic                clk,
  input logic                rstN,
  input logic [1:0]          opSel,
  input logic [DATA_W-1:0]   dataIn,
  input logic [AMT_IN_W-1:0] amtIn,
  input logic [DATA_W-1:0]   dataOut,
  input logic                carryOut,
  input logic                carryUpd
);

  localparam int LOG_W = $clog2(DATA_W);
  logic [AMT_USE_W-1:0] amt;
  assign amt = amtIn[AMT_USE_W-1:0];

  // R8: no stray carry when no update is signalled
  assert_quiet_carry_R8: assert property (@(posedge clk) disable iff (!rstN)
    !carryUpd |-> !carryOut);

  if (REG_OUT) begin : g_seq
    assert_zero_pass_R2: assert property (@(posedge clk) disable iff (!rstN)
      (amt == '0) |=> (dataOut == $past(dataIn)) && !carryUpd);

    assert_lsl_beyond_R3: assert property (@(posedge clk) disable iff (!rstN)
      (opSel == 2'b00 && int'(amt) > DATA_W) |=> (dataOut == '0) && !carryOut && carryUpd);

    assert_lsr_exact_R4: assert property (@(posedge clk) disable iff (!rstN)
      (opSel == 2'b01 && int'(amt) == DATA_W) |=>
        (dataOut == '0) && (carryOut == $past(dataIn[DATA_W-1])) && carryUpd);

    assert_asr_fill_R5: assert property (@(posedge clk) disable iff (!rstN)
      (opSel == 2'b10 && int'(amt) >= DATA_W) |=>
        (dataOut == {DATA_W{$past(dataIn[DATA_W-1])}}) && (carryOut == $past(dataIn[DATA_W-1])));

    assert_rot_wrap_R7: assert property (@(posedge clk) disable iff (!rstN)
      (opSel == 2'b11 && amt != '0 && amt[LOG_W-1:0] == '0) |=>
        (dataOut == $past(dataIn)) && (carryOut == $past(dataIn[DATA_W-1])) && carryUpd);

    assert_upd_nonzero_R8: assert property (@(posedge clk) disable iff (!rstN)
      (amt != '0) |=> carryUpd);
  end

endmodule

bind regshift_unit regshift_checker #(
  .DATA_W(DATA_W), .AMT_IN_W(AMT_IN_W), .AMT_USE_W(AMT_USE_W), .REG_OUT(REG_OUT)
) u_chk (.*);

// File: tb/sim_regshift_unit.sv
module sim_regshift_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  opSel = '0;
  logic [31:0] dataIn = '0;
  logic [31:0] amtIn = '0;
  logic [31:0] dataOut;
  logic        carryOut;
  logic        carryUpd;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  regshift_unit u0 (
    .clk(clk), .rstN(rstN), .opSel(opSel), .dataIn(dataIn), .amtIn(amtIn),
    .dataOut(dataOut), .carryOut(carryOut), .carryUpd(carryUpd)
  );

  // returns {upd, carry, data}
  function automatic logic [33:0] model(input logic [1:0] op, input logic [31:0] d,
                                        input logic [31:0] a);
    int s;
    int r;
    logic [31:0] res;
    logic c;
    logic u;
    s = int'(a[7:0]);
    res = d; c = 1'b0; u = 1'b1;
    if (s == 0) begin
      u = 1'b0;
    end else begin
      case (op)
        2'b00: if (s < 32) begin res = d << s; c = d[32-s]; end
               else if (s == 32) begin res = '0; c = d[0]; end
               else begin res = '0; c = 1'b0; end
        2'b01: if (s < 32) begin res = d >> s; c = d[s-1]; end
               else if (s == 32) begin res = '0; c = d[31]; end
               else begin res = '0; c = 1'b0; end
        2'b10: if (s < 32) begin res = 32'($signed(d) >>> s); c = d[s-1]; end
               else begin res = {32{d[31]}}; c = d[31]; end
        default: begin
          r = s % 32;
          if (r == 0) begin res = d; c = d[31]; end
          else begin res = (d >> r) | (d << (32 - r)); c = d[r-1]; end
        end
      endcase
    end
    return {u, c, res};
  endfunction

  function automatic string tagFor(input logic [1:0] op, input logic [31:0] a);
    if (a[7:0] == 8'd0) return "R2";
    if (op == 2'b11 && a[4:0] == 5'd0) return "R7";
    case (op)
      2'b00:   return "R3";
      2'b01:   return "R4";
      2'b10:   return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic compare(input string tag, input logic [33:0] got, input logic [33:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got upd=%0b carry=%0b data=%h, expected upd=%0b carry=%0b data=%h",
               tag, got[33], got[32], got[31:0], exp[33], exp[32], exp[31:0]);
    end
  endtask

  // drive at a falling edge, result is registered at the next rising edge
  task automatic apply(input string tag, input logic [1:0] op, input logic [31:0] d,
                       input logic [31:0] a);
    @(negedge clk);
    opSel = op; dataIn = d; amtIn = a;
    @(negedge clk);
    compare(tag, {carryUpd, carryOut, dataOut}, model(op, d, a));
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    dataIn = 32'hDEAD_BEEF; amtIn = 32'd5; opSel = 2'b01;
    repeat (3) @(negedge clk);
    compare("R9 reset", {carryUpd, carryOut, dataOut}, 34'd0);
    rstN = 1'b1;

    // directed corner cases
    for (int op = 0; op < 4; op++) begin
      apply(tagFor(2'(op), 0), 2'(op), 32'h8000_0001, 32'd0);
      apply("R8 zero amount", 2'(op), 32'hFFFF_FFFF, 32'h0000_0000);
      apply(tagFor(2'(op), 1), 2'(op), 32'h8000_0001, 32'd1);
      apply(tagFor(2'(op), 31), 2'(op), 32'hC000_0003, 32'd31);
      apply(tagFor(2'(op), 32), 2'(op), 32'h8000_0001, 32'd32);
      apply(tagFor(2'(op), 32), 2'(op), 32'h7FFF_FFFE, 32'd32);
      apply(tagFor(2'(op), 33), 2'(op), 32'hFFFF_FFFF, 32'd33);
      apply(tagFor(2'(op), 64), 2'(op), 32'h8123_4567, 32'd64);
      apply(tagFor(2'(op), 255), 2'(op), 32'h9ABC_DEF1, 32'd255);
      // R1: high amount bits ignored
      apply("R1 high bits", 2'(op), 32'h1357_9BDF, 32'hFFFF_FF00);
      apply("R1 high bits", 2'(op), 32'h8642_0ECA, 32'hABCD_0120);
      apply("R1 high bits", 2'(op), 32'hF0F0_1234, 32'h0000_0104);
    end
    apply("R7", 2'b11, 32'h0000_0001, 32'd96);
    apply("R7", 2'b11, 32'h8000_0000, 32'd224);

    // constrained random
    for (int n = 0; n < 600; n++) begin
      logic [1:0]  op;
      logic [31:0] d;
      logic [31:0] a;
      op = 2'($urandom_range(0, 3));
      d  = $urandom;
      a  = $urandom;
      case ($urandom_range(0, 3))
        0: a[7:0] = 8'($urandom_range(0, 31));
        1: a[7:0] = 8'($urandom_range(30, 34));
        2: a[7:0] = {3'($urandom_range(0, 7)), 5'd0};
        default: ;
      endcase
      apply(tagFor(op, a), op, d, a);
    end

    // R9: outputs hold until the next rising edge
    @(negedge clk);
    opSel = 2'b00; dataIn = 32'h0000_0001; amtIn = 32'd4;
    @(negedge clk);
    opSel = 2'b01; dataIn = 32'h0000_0100; amtIn = 32'd8;
    #2;
    compare("R9 latency", {carryUpd, carryOut, dataOut}, {1'b1, 1'b0, 32'h0000_0010});
    @(negedge clk);
    compare("R9 latency", {carryUpd, carryOut, dataOut}, {1'b1, 1'b0, 32'h0000_0001});

    rstN = 1'b0;
    #1;
    compare("R9 async reset", {carryUpd, carryOut, dataOut}, 34'd0);

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: run did not finish, got timeout, expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

endmodule